// File: doc/BRIEF.md
# Self-Timed Byte Program and Bulk Erase Sequencer

This block takes a single start request and runs a complete write operation on a byte-wide non-volatile array without further help from the host. A program operation needs only a target address and a data byte. The sequencer applies a program strobe of fixed length, reads the byte back, and repeats until the byte matches or its attempt budget is used up. A bulk erase clears the whole array. It first walks every address from zero to the top and programs each one to 00h with the same pulse-and-check loop. It then applies whole-array erase strobes and checks that every byte reads FFh.

While an operation runs, the block shows a polling byte whose top bit is the inverse of the top bit of the value it is working towards. When the operation ends it gives a one-cycle completion pulse and a pass/fail flag, and the polling byte then shows the last byte it read. Pulse lengths and attempt budgets are parameters. The array itself, including its analog behaviour, lies outside the block.

Top module: `flash_algo_seq`

## Requirements
- R1: A start with `op_erase_i`=0 programs `data_i` at `addr_i`. Each program strobe is followed by one read-back cycle. The operation ends with `fail_o`=0 as soon as the read-back equals `data_i`.
- R2: Every program strobe stays high for exactly PW_PGM cycles, and every erase strobe for exactly PW_ERS cycles. Address and write data do not change during a strobe.
- R3: If the read-back after MAX_PGM program strobes still differs from the target, the program operation ends with `fail_o`=1.
- R4: A start with `op_erase_i`=1 first programs and checks 00h at every address in ascending order. No erase strobe is issued before the top address reads 00h.
- R5: The erase check walks the addresses upward from 0. On the first byte that is not FFh it issues another erase strobe and resumes checking at that same address. The erase passes once the top address reads FFh.
- R6: If a byte still differs from FFh after MAX_ERS erase strobes, the erase ends with `fail_o`=1.
- R7: If any byte fails to reach 00h during the pre-program walk (MAX_PGM strobes at that address), the erase ends with `fail_o`=1. No erase strobe is issued and no higher address is touched.
- R8: While busy, `status_o` bit 7 is the inverse of bit 7 of the current target and bits 6:0 are 0. The target is `data_i` when programming, 00h during pre-program (status 80h) and FFh during erase (status 00h). When idle, `status_o` holds the byte read in the final check.
- R9: `busy_o` is high from the cycle after an accepted start until the operation ends. `done_o` then pulses for one cycle with `busy_o` low. `fail_o` holds its value until the next accepted start.
- R10: A start request while busy is ignored: the running operation continues unchanged and completes only once.
- R11: A synchronous `rst` aborts any operation. In the next cycle the block is idle with both strobes low and no completion pulse. A start in the same cycle as `rst` is not accepted.
- R12: The program and erase strobes are never high together, and no erase strobe occurs during a program operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, aborts any operation |
| start_i | input | 1 | Start request, accepted only when idle |
| op_erase_i | input | 1 | 1 = bulk erase, 0 = single-byte program |
| addr_i | input | AW | Target address for program |
| data_i | input | DW | Target data for program |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Result of the last operation, 1 = failed |
| status_o | output | DW | Polling byte while busy, last read byte when idle |
| arr_addr_o | output | AW | Array address |
| arr_wdata_o | output | DW | Array write data |
| arr_prog_o | output | 1 | Program strobe |
| arr_erase_o | output | 1 | Whole-array erase strobe |
| arr_rdata_i | input | DW | Array read data for the current address |

## Verification
Two events can land in the same cycle: a synchronous reset, and a start request that the idle sequencer would otherwise accept. The bench raises both in one cycle and then checks that `busy_o` stays low, so the reset must win over the start. A second test aborts an erase in mid-walk with reset. The bench then checks that no completion pulse appears afterwards and that a fresh program still runs to a pass. This shows that no stale attempt count or address is carried over from the aborted run.

// File: rtl/fas_pkg.sv
package fas_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_PPULSE  = 3'd1,
      ST_PVERIFY = 3'd2,
      ST_EPULSE  = 3'd3,
      ST_EVERIFY = 3'd4
   } seq_state_e;

endpackage

// File: rtl/fas_pulse_timer.sv
module fas_pulse_timer #(
   parameter int TW = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load_i,
   input  logic [TW-1:0] len_i,
   output logic          last_o
);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)                 cnt_q <= '0;
      else if (load_i)         cnt_q <= len_i - 1'b1;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign last_o = (cnt_q == '0);

   // R2: a strobe of zero length would collapse the pulse
   a_r2_len_nonzero: assert property (@(posedge clk) disable iff (rst)
      load_i |-> (len_i != '0));

endmodule

// File: rtl/fas_attempt_ctr.sv
module fas_attempt_ctr #(
   parameter int LIMIT = 25,
   parameter int CW    = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic clr_i,
   input  logic inc_i,
   output logic spent_o
);

   logic [CW-1:0] cnt_q;

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("fas_attempt_ctr: LIMIT must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || clr_i) cnt_q <= '0;
      else if (inc_i)   cnt_q <= cnt_q + 1'b1;
   end

   assign spent_o = (cnt_q == CW'(LIMIT));

   // R3 / R6: the sequencer never issues a pulse beyond its budget
   a_r3_r6_no_overrun: assert property (@(posedge clk) disable iff (rst)
      (inc_i && !clr_i) |-> (cnt_q < CW'(LIMIT)));

endmodule

// File: rtl/flash_algo_seq.sv
module flash_algo_seq
   import fas_pkg::*;
#(
   parameter int AW      = 4,
   parameter int DW      = 8,
   parameter int PW_PGM  = 4,
   parameter int PW_ERS  = 6,
   parameter int MAX_PGM = 25,
   parameter int MAX_ERS = 1000
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start_i,
   input  logic          op_erase_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] data_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          fail_o,
   output logic [DW-1:0] status_o,
   output logic [AW-1:0] arr_addr_o,
   output logic [DW-1:0] arr_wdata_o,
   output logic          arr_prog_o,
   output logic          arr_erase_o,
   input  logic [DW-1:0] arr_rdata_i
);

   localparam int            PW_MAX   = (PW_PGM > PW_ERS) ? PW_PGM : PW_ERS;
   localparam int            TW       = $clog2(PW_MAX + 1);
   localparam logic [AW-1:0] TOP_ADDR = '1;
   localparam logic [DW-1:0] ERASED   = '1;

   generate
      if (AW < 1) begin : g_bad_aw
         $error("flash_algo_seq: AW must be at least 1");
      end
      if (DW < 2) begin : g_bad_dw
         $error("flash_algo_seq: DW must be at least 2");
      end
      if (PW_PGM < 1 || PW_ERS < 1) begin : g_bad_pw
         $error("flash_algo_seq: pulse widths must be at least 1");
      end
   endgenerate

   seq_state_e    st_q, nxt;
   logic          is_erase_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] tgt_q;
   logic [DW-1:0] res_q;
   logic          done_q, fail_q;

   logic          tmr_last, tmr_load;
   logic [TW-1:0] tmr_len;
   logic          pgm_spent, ers_spent;
   logic          pgm_inc, pgm_clr, ers_inc, ers_clr;
   logic          accept, rd_ok_p, rd_ok_e;
   logic          finish, fin_fail;
   logic          exp_msb;

   assign accept  = (st_q == ST_IDLE) && start_i;
   assign rd_ok_p = (arr_rdata_i == tgt_q);
   assign rd_ok_e = (arr_rdata_i == ERASED);

   always_comb begin
      nxt      = st_q;
      finish   = 1'b0;
      fin_fail = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (start_i) nxt = ST_PPULSE;
         end
         ST_PPULSE: begin
            if (tmr_last) nxt = ST_PVERIFY;
         end
         ST_PVERIFY: begin
            if (rd_ok_p) begin
               if (!is_erase_q) begin
                  finish = 1'b1;
                  nxt    = ST_IDLE;
               end else if (addr_q == TOP_ADDR) begin
                  nxt = ST_EPULSE;
               end else begin
                  nxt = ST_PPULSE;
               end
            end else if (pgm_spent) begin
               finish   = 1'b1;
               fin_fail = 1'b1;
               nxt      = ST_IDLE;
            end else begin
               nxt = ST_PPULSE;
            end
         end
         ST_EPULSE: begin
            if (tmr_last) nxt = ST_EVERIFY;
         end
         ST_EVERIFY: begin
            if (rd_ok_e) begin
               if (addr_q == TOP_ADDR) begin
                  finish = 1'b1;
                  nxt    = ST_IDLE;
               end
            end else if (ers_spent) begin
               finish   = 1'b1;
               fin_fail = 1'b1;
               nxt      = ST_IDLE;
            end else begin
               nxt = ST_EPULSE;
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   assign tmr_load = ((nxt == ST_PPULSE) && (st_q != ST_PPULSE)) ||
                     ((nxt == ST_EPULSE) && (st_q != ST_EPULSE));
   assign tmr_len  = (nxt == ST_EPULSE) ? TW'(PW_ERS) : TW'(PW_PGM);

   assign pgm_inc = (st_q == ST_PPULSE) && tmr_last;
   assign pgm_clr = accept || ((st_q == ST_PVERIFY) && rd_ok_p);
   assign ers_inc = (st_q == ST_EPULSE) && tmr_last;
   assign ers_clr = accept;

   fas_pulse_timer #(.TW(TW)) u_timer (
      .clk    (clk),
      .rst    (rst),
      .load_i (tmr_load),
      .len_i  (tmr_len),
      .last_o (tmr_last)
   );

   fas_attempt_ctr #(.LIMIT(MAX_PGM)) u_pgm_budget (
      .clk     (clk),
      .rst     (rst),
      .clr_i   (pgm_clr),
      .inc_i   (pgm_inc),
      .spent_o (pgm_spent)
   );

   fas_attempt_ctr #(.LIMIT(MAX_ERS)) u_ers_budget (
      .clk     (clk),
      .rst     (rst),
      .clr_i   (ers_clr),
      .inc_i   (ers_inc),
      .spent_o (ers_spent)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q       <= ST_IDLE;
         is_erase_q <= 1'b0;
         addr_q     <= '0;
         tgt_q      <= '0;
         res_q      <= '0;
         done_q     <= 1'b0;
         fail_q     <= 1'b0;
      end else begin
         st_q   <= nxt;
         done_q <= finish;
         if (accept) begin
            is_erase_q <= op_erase_i;
            addr_q     <= op_erase_i ? '0 : addr_i;
            tgt_q      <= op_erase_i ? '0 : data_i;
            fail_q     <= 1'b0;
         end
         if ((st_q == ST_PVERIFY) && rd_ok_p && is_erase_q)
            addr_q <= addr_q + 1'b1;
         if ((st_q == ST_EVERIFY) && rd_ok_e && (addr_q != TOP_ADDR))
            addr_q <= addr_q + 1'b1;
         if (finish) begin
            fail_q <= fin_fail;
            res_q  <= arr_rdata_i;
         end
      end
   end

   assign exp_msb     = ((st_q == ST_EPULSE) || (st_q == ST_EVERIFY)) ? 1'b1 : tgt_q[DW-1];
   assign busy_o      = (st_q != ST_IDLE);
   assign done_o      = done_q;
   assign fail_o      = fail_q;
   assign status_o    = busy_o ? {~exp_msb, {(DW-1){1'b0}}} : res_q;
   assign arr_addr_o  = addr_q;
   assign arr_wdata_o = tgt_q;
   assign arr_prog_o  = (st_q == ST_PPULSE);
   assign arr_erase_o = (st_q == ST_EPULSE);

   // R12: strobes exclusive
   a_r12_one_strobe: assert property (@(posedge clk) disable iff (rst)
      !(arr_prog_o && arr_erase_o));

   // R12: a program operation never erases
   a_r12_no_erase_in_pgm: assert property (@(posedge clk) disable iff (rst)
      (busy_o && !is_erase_q) |-> !arr_erase_o);

   // R2: address and data held across a program strobe
   a_r2_pulse_hold: assert property (@(posedge clk) disable iff (rst)
      (arr_prog_o && $past(arr_prog_o)) |-> ($stable(arr_addr_o) && $stable(arr_wdata_o)));

   // R10: a start while busy does not disturb the operation
   a_r10_busy_start: assert property (@(posedge clk) disable iff (rst)
      (busy_o && start_i) |=> ($stable(is_erase_q) && $stable(tgt_q)));

   // R9: completion pulse only on the busy-to-idle step
   a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (!busy_o && $past(busy_o)));

   // R11: reset returns to idle in the next cycle
   a_r11_reset_idle: assert property (@(posedge clk)
      rst |=> (!busy_o && !arr_prog_o && !arr_erase_o && !done_o));

   // R8: only the top bit of the polling byte carries information
   a_r8_poll_msb_only: assert property (@(posedge clk) disable iff (rst)
      busy_o |-> (status_o[DW-2:0] == '0));

endmodule

// File: tb/flash_algo_seq_bench.sv
module flash_algo_seq_bench;

   localparam int AW = 4, DW = 8, PWP = 4, PWE = 6, MAXP = 25, MAXE = 1000;
   localparam int NEED = 3, DEPTH = 16;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst = 1'b1, start = 1'b0, op_erase = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] data = '0;
   logic          busy, done, fail, a_prog, a_ers;
   logic [DW-1:0] status, a_wd, a_rd;
   logic [AW-1:0] a_addr;

   flash_algo_seq u_flash_algo_seq (
      .clk(clk), .rst(rst), .start_i(start), .op_erase_i(op_erase),
      .addr_i(addr), .data_i(data), .busy_o(busy), .done_o(done),
      .fail_o(fail), .status_o(status), .arr_addr_o(a_addr),
      .arr_wdata_o(a_wd), .arr_prog_o(a_prog), .arr_erase_o(a_ers),
      .arr_rdata_i(a_rd)
   );

   // array model, staging and monitors
   logic [7:0] mem [DEPTH];
   int         pcnt [DEPTH];
   logic [7:0] st_mem [DEPTH];
   int         st_hard [DEPTH];
   logic [7:0] st_stick [DEPTH];
   logic       ld_req = 1'b0;
   logic       cur_erase = 1'b0;
   logic [7:0] cur_data = '0;
   int epulses, prog_pulses, ers_pulses, busy_cycles, vreads, vreads0;
   int run_bad, stat_bad, done_cnt, prun, erun;
   logic pv, ev, seen_ers;
   logic [7:0] exp_st;

   assign a_rd = mem[a_addr];

   always @(negedge clk) begin
      if (ld_req) begin
         for (int i = 0; i < DEPTH; i++) begin mem[i] = st_mem[i]; pcnt[i] = 0; end
         epulses = 0; prog_pulses = 0; ers_pulses = 0; busy_cycles = 0;
         vreads = 0; vreads0 = 0; run_bad = 0; stat_bad = 0; done_cnt = 0;
         prun = 0; erun = 0; pv = 1'b0; ev = 1'b0; seen_ers = 1'b0;
      end else begin
         if (a_prog && !pv) begin
            prog_pulses++;
            pcnt[a_addr]++;
            if (pcnt[a_addr] == NEED) begin
               mem[a_addr] = (mem[a_addr] & a_wd) | (mem[a_addr] & st_stick[a_addr]);
               pcnt[a_addr] = 0;
            end
         end
         if (a_ers && !ev) begin
            ers_pulses++; epulses++; seen_ers = 1'b1;
            for (int i = 0; i < DEPTH; i++) if (epulses >= st_hard[i]) mem[i] = 8'hFF;
         end
         if (a_prog) prun++;
         else if (pv) begin if (prun != PWP) run_bad++; prun = 0; end
         if (a_ers) erun++;
         else if (ev) begin if (erun != PWE) run_bad++; erun = 0; end
         if (busy) begin
            busy_cycles++;
            if (!a_prog && !a_ers && seen_ers) begin
               vreads++;
               if (a_addr == 0) vreads0++;
            end
            if (cur_erase) exp_st = seen_ers ? 8'h00 : 8'h80;
            else           exp_st = {~cur_data[7], 7'b0};
            if (status != exp_st) stat_bad++;
         end
         if (done) done_cnt++;
         pv = a_prog; ev = a_ers;
      end
   end

   int nchk = 0, nfail = 0;

   task automatic chk(input string r, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", r, act, exp);
      end
   endtask

   task automatic load_model();
      @(posedge clk); #1; ld_req = 1'b1;
      @(posedge clk); #1; ld_req = 1'b0;
   endtask

   task automatic do_start(input logic e, input logic [AW-1:0] a, input logic [7:0] d);
      @(posedge clk); #1; start = 1'b1; op_erase = e; addr = a; data = d;
      @(posedge clk); #1; start = 1'b0;
   endtask

   task automatic wait_done(input int lim);
      int n = 0;
      while (!done && n < lim) begin @(posedge clk); #1; n++; end
      chk("R9 done pulse reached", int'(done), 1);
   endtask

   task automatic fill(input logic [7:0] v);
      for (int i = 0; i < DEPTH; i++) begin st_mem[i] = v; st_hard[i] = 1; st_stick[i] = 8'h00; end
   endtask

   initial begin
      #(4 * 150000);
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk + 1);
      $finish;
   end

   initial begin
      int errs, expp;
      fill(8'hFF);
      repeat (3) @(posedge clk);
      #1; rst = 1'b0;
      load_model();
      // reset state
      chk("R11 reset busy", int'(busy), 0);
      chk("R9 reset done", int'(done), 0);
      chk("R9 reset fail", int'(fail), 0);
      chk("R12 reset strobes", int'(a_prog) + int'(a_ers), 0);
      chk("R8 reset status", int'(status), 0);

      // R1 R2 R8: program sweep over every address
      for (int a = 0; a < DEPTH; a++) begin
         logic [7:0] d;
         d = 8'((a * 37 + 11) & 8'hFF);
         fill(8'hFF); cur_erase = 1'b0; cur_data = d;
         load_model();
         do_start(1'b0, AW'(a), d);
         wait_done(2000);
         chk("R1 program pass", int'(fail), 0);
         chk("R1 array byte", int'(mem[a]), int'(d));
         chk("R1 program strobes", prog_pulses, NEED);
         chk("R2 busy cycles", busy_cycles, NEED * (PWP + 1));
         chk("R2 strobe widths", run_bad, 0);
         chk("R8 busy polling byte", stat_bad, 0);
         chk("R8 idle status", int'(status), int'(d));
         chk("R12 no erase strobe", ers_pulses, 0);
      end

      // R3: program a byte that cannot reach the target
      fill(8'hFF); st_mem[5] = 8'h00; cur_erase = 1'b0; cur_data = 8'hFF;
      load_model();
      do_start(1'b0, 4'd5, 8'hFF);
      wait_done(5000);
      chk("R3 program fail flag", int'(fail), 1);
      chk("R3 strobe budget", prog_pulses, MAXP);
      chk("R8 idle status after fail", int'(status), 8'h00);
      chk("R8 polling during program", stat_bad, 0);
      repeat (4) @(posedge clk);
      #1;
      chk("R9 fail held", int'(fail), 1);

      // R3: partial overlap, bits can only clear
      fill(8'hFF); st_mem[9] = 8'hA5; cur_data = 8'h5A;
      load_model();
      do_start(1'b0, 4'd9, 8'h5A);
      wait_done(5000);
      chk("R3 overlap fail", int'(fail), 1);
      chk("R3 overlap strobes", prog_pulses, MAXP);
      chk("R3 overlap byte", int'(mem[9]), 0);

      // R4 R5: erase with staggered hardness
      expp = 0;
      for (int i = 0; i < DEPTH; i++) begin
         st_mem[i] = (i % 4 == 0) ? 8'h00 : (8'((i * 29) & 8'hFF) | 8'h01);
         st_hard[i] = 1 + (i % 3);
         st_stick[i] = 8'h00;
         expp += (st_mem[i] == 8'h00) ? 1 : NEED;
      end
      cur_erase = 1'b1;
      load_model();
      do_start(1'b1, '0, '0);
      wait_done(20000);
      chk("R5 erase pass", int'(fail), 0);
      chk("R4 preprogram strobes", prog_pulses, expp);
      chk("R5 erase strobes", ers_pulses, 3);
      chk("R5 verify reads", vreads, DEPTH + 3 - 1);
      chk("R5 restart not at zero", vreads0, 1);
      errs = 0;
      for (int i = 0; i < DEPTH; i++) if (mem[i] != 8'hFF) errs++;
      chk("R5 array erased", errs, 0);
      chk("R8 erase status", int'(status), 8'hFF);
      chk("R8 erase polling", stat_bad, 0);
      chk("R2 erase strobe widths", run_bad, 0);
      repeat (3) @(posedge clk);
      #1;
      chk("R9 single done", done_cnt, 1);

      // R6: one byte never erases
      fill(8'hFF); st_hard[11] = 5000; cur_erase = 1'b1;
      load_model();
      do_start(1'b1, '0, '0);
      wait_done(20000);
      chk("R6 erase fail", int'(fail), 1);
      chk("R6 erase budget", ers_pulses, MAXE);
      chk("R5 resume reads", vreads, 12 + MAXE - 1);

      // R7: a byte that cannot reach zero in pre-program
      fill(8'hFF); st_stick[7] = 8'h01; cur_erase = 1'b1;
      load_model();
      do_start(1'b1, '0, '0);
      wait_done(20000);
      chk("R7 preprogram fail", int'(fail), 1);
      chk("R7 preprogram strobes", prog_pulses, 7 * NEED + MAXP);
      chk("R7 no erase strobe", ers_pulses, 0);
      chk("R7 higher byte untouched", int'(mem[8]), 8'hFF);
      chk("R4 lower byte zeroed", int'(mem[6]), 0);

      // R10: start while busy
      fill(8'hFF); cur_erase = 1'b1;
      load_model();
      do_start(1'b1, '0, '0);
      repeat (30) @(posedge clk);
      #1; start = 1'b1; op_erase = 1'b0; addr = 4'd3; data = 8'h00;
      @(posedge clk); #1; start = 1'b0;
      wait_done(20000);
      chk("R10 erase unaffected", int'(fail), 0);
      chk("R10 byte erased", int'(mem[3]), 8'hFF);
      chk("R10 preprogram strobes", prog_pulses, DEPTH * NEED);
      repeat (5) @(posedge clk);
      #1;
      chk("R10 single completion", done_cnt, 1);
      chk("R10 idle after", int'(busy), 0);

      // R11: abort by reset
      fill(8'hFF); cur_erase = 1'b1;
      load_model();
      do_start(1'b1, '0, '0);
      repeat (20) @(posedge clk);
      #1; rst = 1'b1;
      @(posedge clk); #1; rst = 1'b0;
      chk("R11 abort idle", int'(busy), 0);
      chk("R11 abort strobes", int'(a_prog) + int'(a_ers), 0);
      repeat (10) @(posedge clk);
      #1;
      chk("R11 no done after abort", done_cnt, 0);
      fill(8'hFF); cur_erase = 1'b0; cur_data = 8'h3C;
      load_model();
      do_start(1'b0, 4'd2, 8'h3C);
      wait_done(2000);
      chk("R11 program after abort", int'(mem[2]), 8'h3C);
      chk("R11 strobes after abort", prog_pulses, NEED);

      // R11: reset and start in the same cycle
      @(posedge clk); #1; rst = 1'b1; start = 1'b1; op_erase = 1'b1;
      @(posedge clk); #1; rst = 1'b0; start = 1'b0;
      chk("R11 start blocked by reset", int'(busy), 0);
      @(posedge clk); #1;
      chk("R11 still idle", int'(busy), 0);

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

endmodule